// File: doc/BRIEF.md
# Serial Frame Transmitter with Holding Register

This block turns bytes into asynchronous serial frames for a single channel. A byte written from the parallel side first lands in a one-entry holding register. On a later baud tick it moves into a shift stage that drives the serial line one bit per tick. Each frame has a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. Static inputs choose 7 or 8 data bits, one of four parity modes and the stop length. Bytes are taken at the first frame boundary, so the stop bits are counted only from the stop length and do not change with the data.

Two status outputs show where the data is. One says a byte is waiting in the holding register. The other says a frame is on the line. A one-cycle completion pulse marks the end of every frame. The baud tick comes from outside the block. The channel runs only while both its clock-enable and transmit-enable inputs are high. Dropping clock-enable returns the channel to idle at once.

Top module: `sertx_unit`

## Requirements
- R1: After reset the serial line is high, both status flags are low and the completion pulse is low.
- R2: A frame opens with one low start bit, after which data bits leave least significant bit first, one bit per baud tick. The line stays high whenever no frame is in progress.
- R3: When `len8` is 1, 8 data bits are sent. When it is 0, 7 data bits are sent and bit 7 of the written byte is not transmitted.
- R4: `par_sel` selects the parity bit that follows the data: 2'b00 sends no parity bit, 2'b01 sends a 0, 2'b10 gives an odd count of ones over data plus parity, and 2'b11 gives an even count.
- R5: When `stop2` is 1, two high stop bits close the frame. When it is 0, one high stop bit closes it.
- R6: `buf_full` rises in the cycle after an accepted write. It stays high until a baud tick moves the byte into an idle shift stage, and that tick clears it.
- R7: `shifting` rises on the tick that loads a byte, and from that same edge the line carries the start bit. It stays high until the tick that ends the last stop bit.
- R8: `tx_irq` is a single-cycle pulse, given exactly once for every frame that finishes.
- R9: A write is ignored when `clk_en` or `tx_en` is low. A write is also ignored while `buf_full` is high, and the byte already waiting is kept.
- R10: When `clk_en` is low, the line is high and both flags are low from the next clock edge on. A frame cut off this way gives no completion pulse.
- R11: If a byte is waiting when a frame's last stop bit ends, that same tick starts the next start bit. No idle bit comes between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| clk_en | input | 1 | Channel clock enable; low clears the channel |
| tx_en | input | 1 | Transmit enable; gates writes and loads |
| par_sel | input | 2 | Parity mode (00 none, 01 zero, 10 odd, 11 even) |
| len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| stop2 | input | 1 | 1: two stop bits, 0: one |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| tx_line | output | 1 | Serial output, idles high |
| buf_full | output | 1 | A byte waits in the holding register |
| shifting | output | 1 | A frame is being sent |
| tx_irq | output | 1 | One-cycle pulse when a frame ends |

## Verification
The hardest cases to reach are the ones that depend on where an event falls relative to the baud tick. Examples are a second write that arrives while the first byte is still waiting, a byte that is loaded on the very tick that ends the previous frame, and `clk_en` dropping in the middle of a frame. The stimulus keeps its own tick phase counter. It places each write a fixed number of cycles after a tick, so it can put a second write in the cycle right after the first, before any tick. It writes the follow-on byte as soon as the holding register empties, so that byte must wait for the frame boundary. For the cut-off case it turns the line checker off, drops the enable about two bits into the frame, and then counts the completion pulses.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int unsigned CHAR_MAX = 8;
  localparam int unsigned FRAME_W  = CHAR_MAX + 4;
  localparam int unsigned CNT_W    = $clog2(FRAME_W);

  typedef enum logic [1:0] {
    PAR_OFF  = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic      len8;
    logic      stop2;
    par_mode_e par;
  } line_cfg_t;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [CNT_W-1:0]   last;
  } frame_t;

  // Full line image, LSB first; unused upper positions stay high so the
  // stop bits need no separate handling.
  function automatic frame_t build_frame(logic [CHAR_MAX-1:0] d, line_cfg_t c);
    frame_t              f;
    logic [CHAR_MAX-1:0] m;
    logic [CNT_W-1:0]    pos;
    logic                par_on;
    logic                pbit;
    m      = c.len8 ? d : {1'b0, d[CHAR_MAX-2:0]};
    par_on = (c.par != PAR_OFF);
    case (c.par)
      PAR_ODD:  pbit = ~^m;
      PAR_EVEN: pbit = ^m;
      default:  pbit = 1'b0;
    endcase
    f.bits                  = '1;
    f.bits[0]               = 1'b0;
    f.bits[1 +: CHAR_MAX-1] = d[CHAR_MAX-2:0];
    if (c.len8) f.bits[CHAR_MAX] = d[CHAR_MAX-1];
    pos = CNT_W'(CHAR_MAX) + CNT_W'(c.len8);
    if (par_on) f.bits[pos] = pbit;
    f.last = CNT_W'(CHAR_MAX) + CNT_W'(c.len8) + CNT_W'(par_on) + CNT_W'(c.stop2);
    return f;
  endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
  import sertx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                allow,
  input  logic                wr_valid,
  input  logic [CHAR_MAX-1:0] wr_data,
  input  logic                take,
  output logic                full,
  output logic [CHAR_MAX-1:0] data
);

  logic                full_q, full_d;
  logic [CHAR_MAX-1:0] data_q, data_d;
  logic                accept;

  assign accept = run & allow & wr_valid & ~full_q;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (!run) begin
      full_d = 1'b0;
    end else if (accept) begin
      full_d = 1'b1;
      data_d = wr_data;
    end else if (take) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign full = full_q;
  assign data = data_q;

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && run && !take |=> full_q); // R6
  AST_KEEP_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> $stable(data_q)); // R9

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                allow,
  input  logic                tick,
  input  logic                have_byte,
  input  logic [CHAR_MAX-1:0] byte_in,
  input  line_cfg_t           cfg,
  output logic                take,
  output logic                line,
  output logic                busy,
  output logic                done
);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               busy_q, busy_d;
  logic               line_q, line_d;
  logic               done_q, done_d;
  logic               at_end;
  frame_t             frm;

  assign frm    = build_frame(byte_in, cfg);
  assign at_end = busy_q & (cnt_q == '0);
  assign take   = run & tick & allow & have_byte & (~busy_q | at_end);

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    line_d = line_q;
    done_d = 1'b0;
    if (!run) begin
      sh_d   = '1;
      cnt_d  = '0;
      busy_d = 1'b0;
      line_d = 1'b1;
    end else if (tick) begin
      if (at_end) begin
        done_d = 1'b1;
        busy_d = 1'b0;
        line_d = 1'b1;
      end else if (busy_q) begin
        sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
        line_d = sh_q[1];
        cnt_d  = cnt_q - 1'b1;
      end
      if (take) begin
        sh_d   = frm.bits;
        cnt_d  = frm.last;
        busy_d = 1'b1;
        line_d = frm.bits[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      line_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      line_q <= line_d;
      done_q <= done_d;
    end
  end

  assign line = line_q;
  assign busy = busy_q;
  assign done = done_q;

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !line_q); // R2
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> line_q); // R2
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && run && !tick |=> $stable(line_q)); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
  AST_CHAIN_START: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && busy_q |-> !line_q); // R11

endmodule

// File: rtl/sertx_unit.sv
module sertx_unit
  import sertx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                baud_tick,
  input  logic                clk_en,
  input  logic                tx_en,
  input  logic [1:0]          par_sel,
  input  logic                len8,
  input  logic                stop2,
  input  logic                wr_valid,
  input  logic [CHAR_MAX-1:0] wr_data,
  output logic                tx_line,
  output logic                buf_full,
  output logic                shifting,
  output logic                tx_irq
);

  logic [1:0]          rst_pipe_q;
  logic                rst_int_n;
  logic                take;
  logic [CHAR_MAX-1:0] held;
  line_cfg_t           cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  always_comb begin
    cfg.len8  = len8;
    cfg.stop2 = stop2;
    cfg.par   = par_mode_e'(par_sel);
  end

  sertx_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (clk_en),
    .allow    (tx_en),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .take     (take),
    .full     (buf_full),
    .data     (held)
  );

  sertx_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (clk_en),
    .allow     (tx_en),
    .tick      (baud_tick),
    .have_byte (buf_full),
    .byte_in   (held),
    .cfg       (cfg),
    .take      (take),
    .line      (tx_line),
    .busy      (shifting),
    .done      (tx_irq)
  );

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !clk_en |=> tx_line && !buf_full && !shifting && !tx_irq); // R10
  AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(shifting) |-> !buf_full); // R7

endmodule

// File: tb/sertx_unit_tb_top.sv
`timescale 1ns/1ps
module sertx_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick;
  logic       clk_en = 1'b0;
  logic       tx_en = 1'b0;
  logic [1:0] par_sel = 2'b00;
  logic       len8 = 1'b0;
  logic       stop2 = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tx_line, buf_full, shifting, tx_irq;

  int  total = 0;
  int  bad = 0;
  int  ph = 0;
  bit  mon_on = 1'b1;
  int  irq_cnt = 0;
  int  frames_seen = 0;
  int  sent = 0;
  bit  finished = 1'b0;

  typedef struct {
    logic [7:0] d;
    logic       l8;
    logic       s2;
    logic [1:0] ps;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) ph <= (ph == 7) ? 0 : ph + 1;
  assign baud_tick = (ph == 0);

  sertx_unit dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .clk_en(clk_en),
    .tx_en(tx_en), .par_sel(par_sel), .len8(len8), .stop2(stop2),
    .wr_valid(wr_valid), .wr_data(wr_data), .tx_line(tx_line),
    .buf_full(buf_full), .shifting(shifting), .tx_irq(tx_irq)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (tx_irq === 1'b1) irq_cnt++;

  // Monitor: pops the expected item and compares each frame field.
  initial begin : monitor
    exp_t       e;
    int         n, len, pos, ones;
    logic       got [12];
    logic [7:0] ob, dm;
    logic       pexp;
    forever begin
      @(negedge clk);
      if (mon_on && rst_n && tx_line === 1'b0) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9", "unexpected frame", 0, 1);
          while (shifting === 1'b1) @(negedge clk);
        end else begin
          e   = q.pop_front();
          len = e.l8 ? 8 : 7;
          n   = 1 + len + ((e.ps != 2'b00) ? 1 : 0) + (e.s2 ? 2 : 1);
          repeat (4) @(negedge clk);
          got[0] = tx_line;
          for (int i = 1; i < n; i++) begin
            repeat (8) @(negedge clk);
            got[i] = tx_line;
          end
          frames_seen++;
          chk(got[0] === 1'b0, "R2", "start bit", got[0], 0);
          ob = 8'h00;
          for (int i = 0; i < len; i++) ob[i] = got[1 + i];
          dm = e.l8 ? e.d : {1'b0, e.d[6:0]};
          chk(ob === dm, "R3", "data bits LSB first (R2)", ob, dm);
          pos = 1 + len;
          if (e.ps != 2'b00) begin
            ones = $countones(dm);
            pexp = (e.ps == 2'b01) ? 1'b0 : (e.ps == 2'b10) ? ~ones[0] : ones[0];
            chk(got[pos] === pexp, "R4", "parity bit", got[pos], pexp);
            pos++;
          end
          chk(got[pos] === 1'b1 && (!e.s2 || got[pos + 1] === 1'b1), "R5",
              "stop bits", {got[pos], (e.s2 ? got[pos + 1] : 1'b1)}, 2'b11);
        end
      end
    end
  end

  task automatic wait_ph(int k);
    do @(negedge clk); while (ph != k);
  endtask

  task automatic wait_idle();
    while (buf_full === 1'b1 || shifting === 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic push(logic [7:0] d);
    exp_t e;
    e.d = d; e.l8 = len8; e.s2 = stop2; e.ps = par_sel;
    q.push_back(e);
    sent++;
  endtask

  // Driver: write one byte from idle, check the flags around the load tick.
  task automatic send(logic [7:0] d, logic l8, logic s2, logic [1:0] ps);
    wait_idle();
    len8 = l8; stop2 = s2; par_sel = ps;
    wait_ph(2);
    wr_data = d; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(buf_full === 1'b1, "R6", "full after write", buf_full, 1);
    push(d);
    wait_ph(1);
    chk({buf_full, shifting, tx_line} === 3'b010, "R7", "load on tick (R6)",
        {buf_full, shifting, tx_line}, 3'b010);
  endtask

  initial begin : main
    int   snap;
    logic [7:0] base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({tx_line, buf_full, shifting, tx_irq} === 4'b1000, "R1", "reset state",
        {tx_line, buf_full, shifting, tx_irq}, 4'b1000);
    clk_en = 1'b1; tx_en = 1'b1;

    for (int c = 0; c < 16; c++) begin
      base = 8'h5A ^ 8'(c * 29);
      send(base, c[2], c[3], c[1:0]);
      send(~base, c[2], c[3], c[1:0]);
    end
    send(8'hFF, 1'b0, 1'b1, 2'b11);
    send(8'h00, 1'b1, 1'b0, 2'b10);

    // R11: second byte waits, then follows with no idle bit
    wait_idle();
    len8 = 1'b1; stop2 = 1'b0; par_sel = 2'b00;
    wait_ph(2);
    wr_data = 8'hA7; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    push(8'hA7);
    wait_ph(1);
    wr_data = 8'h1E; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(buf_full === 1'b1, "R6", "byte waits while shifting", buf_full, 1);
    push(8'h1E);
    while (tx_irq !== 1'b1) @(negedge clk);
    chk({tx_line, shifting, buf_full} === 3'b010, "R11", "chained start",
        {tx_line, shifting, buf_full}, 3'b010);

    // R9: write with transmit disabled
    wait_idle();
    tx_en = 1'b0;
    wait_ph(2);
    wr_data = 8'h33; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(buf_full === 1'b0, "R9", "write with tx_en low", buf_full, 0);
    repeat (24) @(negedge clk);
    chk({shifting, tx_line} === 2'b01, "R9", "no frame with tx_en low",
        {shifting, tx_line}, 2'b01);
    tx_en = 1'b1;

    // R9: second write while full is dropped
    wait_idle();
    wait_ph(2);
    wr_data = 8'hC3; wr_valid = 1'b1;
    @(negedge clk);
    push(8'hC3);
    wr_data = 8'h3C;
    @(negedge clk);
    wr_valid = 1'b0;
    wait_idle();
    repeat (16) @(negedge clk);
    chk(q.size() == 0 && frames_seen == sent, "R9", "only first byte sent",
        frames_seen, sent);

    // R10: cut a frame off by clearing clk_en
    wait_idle();
    mon_on = 1'b0;
    snap = irq_cnt;
    wait_ph(2);
    wr_data = 8'h96; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(shifting === 1'b1, "R10", "busy before abort", shifting, 1);
    clk_en = 1'b0;
    @(negedge clk);
    chk({tx_line, buf_full, shifting} === 3'b100, "R10", "cleared by clk_en",
        {tx_line, buf_full, shifting}, 3'b100);
    repeat (30) @(negedge clk);
    chk(irq_cnt == snap && tx_line === 1'b1, "R10", "no pulse after abort",
        irq_cnt, snap);
    clk_en = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    chk(irq_cnt == sent, "R8", "one pulse per frame", irq_cnt, sent);
    chk(q.size() == 0, "R2", "all frames observed", q.size(), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule